// File: doc/BRIEF.md
# Platform interrupt controller with privilege-mapped levels

This block gathers level-sensitive interrupt wires from platform devices and fans them out to a small set of harts. Each source owns a sticky pending flag, a 2-bit destination level and one enable bit per hart. Every hart receives four interrupt lines, one for each privilege level (M, H, S, U). The 2-bit level does not rank sources against each other. It only selects which of the four lines a source drives.

Software reaches the state through a word-addressed register port with 64-bit data. It acknowledges an interrupt by writing the pending word back with the bit cleared. A write stores the data word as given, so writing a one raises a source by software. The level is held in two separate bit planes, one for the low bit and one for the high bit, so one word carries the same level bit for 64 sources. In the intended system the console serial port is wired to source 3.

Top module: `pirq_ctrl`

## Requirements
- R1: After reset, all pending flags, both level planes and all enable bits are zero, every `irq_o` line is low, and every register reads zero.
- R2: A source whose input is high at a clock edge has its pending bit set after that edge, unless that same edge writes the source's pending word. A set pending bit stays set after its input falls, until software writes it.
- R3: A write to pending word w (address w) replaces that word with `wdata_i` and takes precedence over capture at the same edge. A source whose input is still high sets its bit again at the following edge.
- R4: Word address SW+w holds the low level bit and address 2*SW+w holds the high level bit of sources 64w to 64w+63, where SW = N_SRC/64. The level is {high,low}, with 0 = M, 1 = H, 2 = S and 3 = U.
- R5: Word address 3*SW + h*SW + w holds the enable bits of hart h for sources 64w to 64w+63. A zero bit keeps that source off all four of hart h's lines.
- R6: `irq_o[4*h+L]` is high exactly when some source is pending, is enabled for hart h and has level L. It follows the register state in the same cycle, with no added delay.
- R7: Reads of addresses at or above 3*SW + N_HART*SW return zero. Writes to those addresses change no state.
- R8: `rdata_o` shows the current contents of the word at `addr_i` in the same cycle, for every mapped address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Level interrupt inputs from the devices |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | High for a write, low for a read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data for `addr_i` (combinational) |
| irq_o | output | 4*N_HART | Per-hart, per-level interrupt lines, index 4*h+L |

## Verification
Capture of a high source input and a software write to the same pending word can land on the same clock edge. The bench provokes this by writing the pending word to zero while a source is held high. It expects the flag to read zero for exactly one cycle and then to return. The same collision also occurs throughout a long random phase. There, a behavioural model that applies write-over-capture ordering is compared with `irq_o` and `rdata_o` on every clock.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int unsigned WORD_W = 64;
  localparam int unsigned N_LVL  = 4;

  typedef enum logic [1:0] {
    LVL_M = 2'd0,
    LVL_H = 2'd1,
    LVL_S = 2'd2,
    LVL_U = 2'd3
  } lvl_e;
endpackage

// File: rtl/pirq_pend.sv
module pirq_pend
  import pirq_pkg::*;
#(
  parameter int unsigned N_SRC = 64,
  localparam int unsigned SW   = N_SRC / WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic [SW-1:0]     wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [N_SRC-1:0]  pend_o
);
  logic [N_SRC-1:0] pend_q;

  for (genvar w = 0; w < SW; w++) begin : g_word
    // a write replaces the word; capture resumes on the next edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    pend_q[w*WORD_W +: WORD_W] <= '0;
      else if (wr_i[w]) pend_q[w*WORD_W +: WORD_W] <= wdata_i;
      else            pend_q[w*WORD_W +: WORD_W] <= pend_q[w*WORD_W +: WORD_W]
                                                  | src_i[w*WORD_W +: WORD_W];
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/pirq_cfg.sv
module pirq_cfg
  import pirq_pkg::*;
#(
  parameter int unsigned N_SRC  = 64,
  parameter int unsigned N_HART = 2,
  localparam int unsigned SW    = N_SRC / WORD_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [SW-1:0]           wr_lo_i,
  input  logic [SW-1:0]           wr_hi_i,
  input  logic [N_HART*SW-1:0]    wr_en_i,
  input  logic [WORD_W-1:0]       wdata_i,
  output logic [N_SRC-1:0]        lvl_lo_o,
  output logic [N_SRC-1:0]        lvl_hi_o,
  output logic [N_HART*N_SRC-1:0] en_o
);
  logic [N_SRC-1:0]        lo_q, hi_q;
  logic [N_HART*N_SRC-1:0] en_q;

  for (genvar w = 0; w < SW; w++) begin : g_plane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q[w*WORD_W +: WORD_W] <= '0;
        hi_q[w*WORD_W +: WORD_W] <= '0;
      end else begin
        if (wr_lo_i[w]) lo_q[w*WORD_W +: WORD_W] <= wdata_i;
        if (wr_hi_i[w]) hi_q[w*WORD_W +: WORD_W] <= wdata_i;
      end
    end
  end

  for (genvar e = 0; e < N_HART*SW; e++) begin : g_en
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        en_q[e*WORD_W +: WORD_W] <= '0;
      else if (wr_en_i[e]) en_q[e*WORD_W +: WORD_W] <= wdata_i;
    end
  end

  assign lvl_lo_o = lo_q;
  assign lvl_hi_o = hi_q;
  assign en_o     = en_q;
endmodule

// File: rtl/pirq_route.sv
module pirq_route
  import pirq_pkg::*;
#(
  parameter int unsigned N_SRC  = 64,
  parameter int unsigned N_HART = 2
) (
  input  logic [N_SRC-1:0]        pend_i,
  input  logic [N_SRC-1:0]        lvl_lo_i,
  input  logic [N_SRC-1:0]        lvl_hi_i,
  input  logic [N_HART*N_SRC-1:0] en_i,
  output logic [N_HART*N_LVL-1:0] irq_o
);
  for (genvar l = 0; l < N_LVL; l++) begin : g_lvl
    localparam logic [1:0] LV = 2'(l);
    logic [N_SRC-1:0] match;
    assign match = (LV[1] ? lvl_hi_i : ~lvl_hi_i) & (LV[0] ? lvl_lo_i : ~lvl_lo_i);
    for (genvar h = 0; h < N_HART; h++) begin : g_hart
      assign irq_o[h*N_LVL + l] = |(pend_i & match & en_i[h*N_SRC +: N_SRC]);
    end
  end
endmodule

// File: rtl/pirq_ctrl.sv
module pirq_ctrl
  import pirq_pkg::*;
#(
  parameter int unsigned N_SRC  = 64,
  parameter int unsigned N_HART = 2,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_SRC-1:0]        src_i,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [WORD_W-1:0]       wdata_i,
  output logic [WORD_W-1:0]       rdata_o,
  output logic [N_HART*N_LVL-1:0] irq_o
);
  localparam int unsigned SW     = N_SRC / WORD_W;
  localparam int unsigned OFF_LO = SW;
  localparam int unsigned OFF_HI = 2 * SW;
  localparam int unsigned OFF_EN = 3 * SW;

  logic                    wr;
  logic [SW-1:0]           wr_pend, wr_lo, wr_hi;
  logic [N_HART*SW-1:0]    wr_en;
  logic [N_SRC-1:0]        pend_w, lo_w, hi_w;
  logic [N_HART*N_SRC-1:0] en_w;

  assign wr = req_i & we_i;

  for (genvar w = 0; w < SW; w++) begin : g_dec
    assign wr_pend[w] = wr && (addr_i == ADDR_W'(w));
    assign wr_lo[w]   = wr && (addr_i == ADDR_W'(OFF_LO + w));
    assign wr_hi[w]   = wr && (addr_i == ADDR_W'(OFF_HI + w));
  end
  for (genvar e = 0; e < N_HART*SW; e++) begin : g_dec_en
    assign wr_en[e] = wr && (addr_i == ADDR_W'(OFF_EN + e));
  end

  pirq_pend #(.N_SRC(N_SRC)) u_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_i   (src_i),
    .wr_i    (wr_pend),
    .wdata_i (wdata_i),
    .pend_o  (pend_w)
  );

  pirq_cfg #(.N_SRC(N_SRC), .N_HART(N_HART)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_lo_i  (wr_lo),
    .wr_hi_i  (wr_hi),
    .wr_en_i  (wr_en),
    .wdata_i  (wdata_i),
    .lvl_lo_o (lo_w),
    .lvl_hi_o (hi_w),
    .en_o     (en_w)
  );

  pirq_route #(.N_SRC(N_SRC), .N_HART(N_HART)) u_route (
    .pend_i   (pend_w),
    .lvl_lo_i (lo_w),
    .lvl_hi_i (hi_w),
    .en_i     (en_w),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < int'(SW); w++) begin
      if (addr_i == ADDR_W'(w))          rdata_o = pend_w[w*WORD_W +: WORD_W];
      if (addr_i == ADDR_W'(OFF_LO + w)) rdata_o = lo_w[w*WORD_W +: WORD_W];
      if (addr_i == ADDR_W'(OFF_HI + w)) rdata_o = hi_w[w*WORD_W +: WORD_W];
    end
    for (int e = 0; e < int'(N_HART*SW); e++) begin
      if (addr_i == ADDR_W'(OFF_EN + e)) rdata_o = en_w[e*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/pirq_ctrl_chk.sv
module pirq_ctrl_chk
  import pirq_pkg::*;
#(
  parameter int unsigned N_SRC  = 64,
  parameter int unsigned N_HART = 2,
  parameter int unsigned ADDR_W = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [N_SRC-1:0]        src_i,
  input logic                    req_i,
  input logic                    we_i,
  input logic [ADDR_W-1:0]       addr_i,
  input logic [WORD_W-1:0]       wdata_i,
  input logic [WORD_W-1:0]       rdata_o,
  input logic [N_HART*N_LVL-1:0] irq_o,
  input logic [N_SRC-1:0]        pend_i
);
  localparam int unsigned SW    = N_SRC / WORD_W;
  localparam int unsigned N_MAP = 3 * SW + N_HART * SW;

  logic pend_wr;
  assign pend_wr = req_i && we_i && (addr_i < ADDR_W'(SW));

  assert_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_wr |=> ((pend_i & $past(src_i)) == $past(src_i)));

  assert_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_wr |=> ((pend_i & $past(pend_i)) == $past(pend_i)));

  for (genvar w = 0; w < SW; w++) begin : g_ack
    assert_write_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && we_i && addr_i == ADDR_W'(w)) |=> (pend_i[w*WORD_W +: WORD_W] == $past(wdata_i)));
  end

  assert_irq_needs_pend_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i == '0) |-> (irq_o == '0));

  assert_unmapped_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i >= ADDR_W'(N_MAP)) |-> (rdata_o == '0));
endmodule

bind pirq_ctrl pirq_ctrl_chk #(.N_SRC(N_SRC), .N_HART(N_HART), .ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .src_i   (src_i),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .pend_i  (pend_w)
);

// File: tb/pirq_ctrl_test.sv
module pirq_ctrl_test;
  localparam int NS = 64;
  localparam int NH = 2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NS-1:0] src = '0;
  logic          req = 1'b0, we = 1'b0;
  logic [7:0]    addr = '0;
  logic [63:0]   wdata = '0;
  logic [63:0]   rdata;
  logic [4*NH-1:0] irq;

  int n_run = 0, n_fail = 0;

  // behavioural model state
  logic [63:0] m_pend, m_lo, m_hi;
  logic [63:0] m_en [NH];

  always #4 clk = ~clk;

  pirq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] m_read(int a);
    case (a)
      0: return m_pend;
      1: return m_lo;
      2: return m_hi;
      3: return m_en[0];
      4: return m_en[1];
      default: return '0;
    endcase
  endfunction

  function automatic logic [4*NH-1:0] m_irq();
    logic [4*NH-1:0] r = '0;
    for (int h = 0; h < NH; h++)
      for (int s = 0; s < NS; s++)
        if (m_pend[s] && m_en[h][s]) r[4*h + int'({m_hi[s], m_lo[s]})] = 1'b1;
    return r;
  endfunction

  function automatic string rtag(int a);
    if (a == 0) return "R3 pending read";
    if (a < 3)  return "R4 level read";
    if (a < 5)  return "R5 enable read";
    return "R7 unmapped read";
  endfunction

  // one clock: drive at negedge, update model at posedge, compare at next negedge
  task automatic cyc(logic [63:0] s, logic r, logic w, int a, logic [63:0] d);
    src = s; req = r; we = w; addr = 8'(a); wdata = d;
    @(posedge clk);
    if (r && w) begin
      case (a)
        0: m_pend = d;
        1: m_lo = d;
        2: m_hi = d;
        3: m_en[0] = d;
        4: m_en[1] = d;
        default: ;
      endcase
    end
    if (!(r && w && a == 0)) m_pend = m_pend | s;
    @(negedge clk);
    chk("R6 irq vs model", 64'(irq), 64'(m_irq()));
    chk(rtag(a), rdata, m_read(a));
  endtask

  task automatic rd(int a);
    cyc('0, 1'b1, 1'b0, a, '0);
  endtask

  task automatic wr(int a, logic [63:0] d);
    cyc('0, 1'b1, 1'b1, a, d);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    m_pend = '0; m_lo = '0; m_hi = '0;
    for (int h = 0; h < NH; h++) m_en[h] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    chk("R1 irq after reset", 64'(irq), 64'h0);
    for (int a = 0; a < 8; a++) begin
      rd(a);
      chk("R1 register after reset", rdata, 64'h0);
    end

    // R4: source 3 -> S (2), 10 -> H (1), 40 -> U (3), 5 -> M (0)
    wr(1, (64'd1 << 10) | (64'd1 << 40));
    wr(2, (64'd1 << 3) | (64'd1 << 40));
    rd(1); chk("R4 low plane", rdata, (64'd1 << 10) | (64'd1 << 40));
    rd(2); chk("R4 high plane", rdata, (64'd1 << 3) | (64'd1 << 40));
    // R5: hart0 gets 3,5,10; hart1 gets 3,40
    wr(3, (64'd1 << 3) | (64'd1 << 5) | (64'd1 << 10));
    wr(4, (64'd1 << 3) | (64'd1 << 40));

    // R2: one-cycle pulse on source 3 is held; both harts see S
    cyc(64'd1 << 3, 1'b0, 1'b0, 0, '0);
    cyc('0, 1'b0, 1'b0, 0, '0);
    chk("R2 pulse held", rdata, 64'd1 << 3);
    chk("R6 S line on both harts", 64'(irq), 64'b0100_0100);

    // R3: acknowledge by clearing with input low
    wr(0, '0);
    chk("R3 ack clears", rdata, 64'h0);
    chk("R3 ack drops irq", 64'(irq), 64'h0);

    // R3: clear while source 10 stays high -> zero for one cycle, then back
    cyc(64'd1 << 10, 1'b0, 1'b0, 0, '0);
    cyc(64'd1 << 10, 1'b1, 1'b1, 0, '0);
    chk("R3 write wins over capture", rdata, 64'h0);
    cyc(64'd1 << 10, 1'b0, 1'b0, 0, '0);
    chk("R3 recapture next cycle", rdata, 64'd1 << 10);
    chk("R6 H line on hart0", 64'(irq), 64'b0000_0010);

    // R3: software raise of source 5 -> M on hart0
    wr(0, 64'd1 << 5);
    chk("R3 software set", rdata, 64'd1 << 5);
    chk("R6 M line on hart0", 64'(irq), 64'b0000_0001);

    // R5: masking source 5 on hart0
    wr(3, 64'd1 << 3);
    chk("R5 masked source", 64'(irq), 64'h0);
    // R5: hart1 U line through source 40
    wr(0, 64'd1 << 40);
    chk("R5 hart1 U line", 64'(irq), 64'b1000_0000);

    // R7: unmapped writes and reads
    wr(5, '1); wr(7, '1); wr(200, '1);
    rd(5); chk("R7 unmapped reads zero", rdata, 64'h0);
    for (int a = 0; a < 5; a++) rd(a);

    // R8: random traffic against the model every clock
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] s = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}
                     & {$urandom, $urandom};
      logic w = ($urandom_range(0, 3) == 0);
      cyc(s, 1'($urandom_range(0, 1)), w, $urandom_range(0, 9), {$urandom, $urandom});
    end
    for (int a = 0; a < 8; a++) begin
      rd(a);
      chk("R8 final readback", rdata, m_read(a));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule